// File: doc/BRIEF.md
# Register Write-Protection Key Lock

This block sits between a simple register-access strobe and a bank of configuration registers. It decides, for every write that reaches the bank, whether the write may land and which bits of it may land. The protected registers stay locked until a two-step key is written to a dedicated key address: first the byte 0xCA, then 0x53 as the very next key write. Any other key value locks the bank again. The lock state lives in its own reset domain. Only the power-on reset clears it. The ordinary system reset leaves it alone.

Some addresses are always writable: a configurable list of single registers and a contiguous window of backup words. One status register is partly writable while locked. Only the bits in a configured free mask pass through, and the remaining bits of that register pass only when the bank is unlocked. Each access is held on the bus by the requester and is acknowledged after a fixed number of wait states. The key state and the bank write qualifier act on the acknowledge cycle.

Top module: `keylock_guard`

## Requirements
- R1: After power-on reset `unlocked` is 0, and a write to an ordinary protected address produces `bank_we` = 0.
- R2: An access whose `acc_req` is held high is acknowledged by `acc_ack` for exactly one cycle, after exactly WAIT_STATES cycles with `acc_ack` low (default 2). The wait count then restarts for the next access.
- R3: A key write (to KEY_ADDR) whose low byte is 0xCA, followed by a key write whose low byte is 0x53 as the next key write, sets `unlocked` to 1 in the cycle after the second acknowledge.
- R4: While locked, a write to the status address STAT_ADDR gives `bank_we` = 1 with `bank_wmask` equal to STAT_FREE_MASK (default bits 13 to 8 set). Writes to other protected addresses are dropped.
- R5: A key write that does not continue the sequence leaves the block locked. This includes a repeated 0xCA right after 0xCA, and 0x53 with no 0xCA before it. Any key write while unlocked locks the bank again. If that write is 0xCA, it also counts as the first step of a new sequence.
- R6: Only bits 7 to 0 of the key write data are compared. Bits above bit 7 have no effect on the sequence.
- R7: A write to an address in the EXEMPT_ADDRS list, or in the backup window BKP_BASE to BKP_BASE+BKP_NUM-1, gives `bank_we` = 1 with a mask of all ones, whatever the lock state.
- R8: Holding `sys_rst_n` low does not change `unlocked`. It only clears a partly counted access.
- R9: While unlocked, writes to protected and status addresses give `bank_we` = 1 with a mask of all ones. A key write never produces `bank_we`.
- R10: Once unlocked, writes to non-key addresses keep the bank unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears the lock state |
| sys_rst_n | input | 1 | System reset, active low, asynchronous; clears only the wait counter |
| acc_req | input | 1 | Write access request, held high until acknowledged |
| acc_addr | input | AW | Word address of the access |
| acc_wdata | input | DW | Write data |
| acc_ack | output | 1 | Access acknowledge after the wait states; the write commits in this cycle |
| bank_we | output | 1 | Qualified write enable to the register bank |
| bank_wmask | output | DW | Bits of the write that the bank may take |
| unlocked | output | 1 | 1 while protected registers are writable |

## Verification
The bench builds the block with its defaults: two wait states, a 32-bit data path, two single exempt addresses, a twenty-word backup window and a status free mask covering bits 13 to 8. This setting covers the partial-mask case on the status register, both kinds of exempt hit, and a wait count that can be cut short by system reset. Random key values weighted toward the two key bytes reach every transition of the key sequence, including a repeated first key, keys with non-zero upper bits, and a relock from the unlocked state.

// File: rtl/keylock_pkg.sv
package keylock_pkg;

    localparam logic [7:0] KEY_STEP1 = 8'hCA;
    localparam logic [7:0] KEY_STEP2 = 8'h53;

    typedef enum logic [1:0] {
        KL_LOCKED = 2'd0,
        KL_HALF   = 2'd1,
        KL_OPEN   = 2'd2
    } kl_state_e;

    typedef struct packed {
        kl_state_e st;
    } kl_fsm_t;

endpackage

// File: rtl/keylock_wait.sv
module keylock_wait #(
    parameter int WAIT_STATES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic ack
);
    localparam int CW = $clog2(WAIT_STATES + 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } wait_t;

    wait_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        ack = req && (w_q.cnt == CW'(WAIT_STATES));
        if (!req || ack) begin
            w_d.cnt = '0;
        end else begin
            w_d.cnt = w_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end
endmodule

// File: rtl/keylock_fsm.sv
module keylock_fsm
    import keylock_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    output logic       unlocked
);
    kl_fsm_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (key_wr) begin
            unique case (f_q.st)
                KL_HALF: f_d.st = (key_byte == KEY_STEP2) ? KL_OPEN : KL_LOCKED;
                default: f_d.st = (key_byte == KEY_STEP1) ? KL_HALF : KL_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            f_q.st <= KL_LOCKED;
        end else begin
            f_q <= f_d;
        end
    end

    assign unlocked = (f_q.st == KL_OPEN);
endmodule

// File: rtl/keylock_gate.sv
module keylock_gate #(
    parameter int              AW             = 8,
    parameter int              DW             = 32,
    parameter logic [AW-1:0]   KEY_ADDR       = 8'h09,
    parameter logic [AW-1:0]   STAT_ADDR      = 8'h03,
    parameter logic [DW-1:0]   STAT_FREE_MASK = 32'h0000_3F00,
    parameter int              N_EXEMPT       = 2,
    parameter logic [N_EXEMPT*AW-1:0] EXEMPT_ADDRS = {8'h0F, 8'h0E},
    parameter int              BKP_BASE       = 20,
    parameter int              BKP_NUM        = 20
) (
    input  logic          commit,
    input  logic [AW-1:0] addr,
    input  logic          unlocked,
    output logic          is_key,
    output logic          bank_we,
    output logic [DW-1:0] bank_wmask
);
    localparam int BKP_END = BKP_BASE + BKP_NUM;

    logic [N_EXEMPT-1:0] ex_hit;
    logic                in_bkp;
    logic                always_ok;
    logic [DW-1:0]       mask;

    for (genvar i = 0; i < N_EXEMPT; i++) begin : g_exempt
        assign ex_hit[i] = (addr == EXEMPT_ADDRS[i*AW +: AW]);
    end

    always_comb begin
        in_bkp    = (int'(addr) >= BKP_BASE) && (int'(addr) < BKP_END);
        always_ok = (|ex_hit) || in_bkp;
        is_key    = (addr == KEY_ADDR);
        if (is_key) begin
            mask = '0;
        end else if (always_ok || unlocked) begin
            mask = '1;
        end else if (addr == STAT_ADDR) begin
            mask = STAT_FREE_MASK;
        end else begin
            mask = '0;
        end
        bank_wmask = commit ? mask : '0;
        bank_we    = commit && (|mask);
    end
endmodule

// File: rtl/keylock_guard.sv
module keylock_guard #(
    parameter int              AW             = 8,
    parameter int              DW             = 32,
    parameter int              WAIT_STATES    = 2,
    parameter logic [AW-1:0]   KEY_ADDR       = 8'h09,
    parameter logic [AW-1:0]   STAT_ADDR      = 8'h03,
    parameter logic [DW-1:0]   STAT_FREE_MASK = 32'h0000_3F00,
    parameter int              N_EXEMPT       = 2,
    parameter logic [N_EXEMPT*AW-1:0] EXEMPT_ADDRS = {8'h0F, 8'h0E},
    parameter int              BKP_BASE       = 20,
    parameter int              BKP_NUM        = 20
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          sys_rst_n,
    input  logic          acc_req,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    output logic          acc_ack,
    output logic          bank_we,
    output logic [DW-1:0] bank_wmask,
    output logic          unlocked
);
    logic cnt_rst_n;
    logic is_key;

    assign cnt_rst_n = por_n && sys_rst_n;

    keylock_wait #(.WAIT_STATES(WAIT_STATES)) u_wait (
        .clk   (clk),
        .rst_n (cnt_rst_n),
        .req   (acc_req),
        .ack   (acc_ack)
    );

    keylock_fsm u_fsm (
        .clk      (clk),
        .por_n    (por_n),
        .key_wr   (acc_ack && is_key),
        .key_byte (acc_wdata[7:0]),
        .unlocked (unlocked)
    );

    keylock_gate #(
        .AW(AW), .DW(DW), .KEY_ADDR(KEY_ADDR), .STAT_ADDR(STAT_ADDR),
        .STAT_FREE_MASK(STAT_FREE_MASK), .N_EXEMPT(N_EXEMPT),
        .EXEMPT_ADDRS(EXEMPT_ADDRS), .BKP_BASE(BKP_BASE), .BKP_NUM(BKP_NUM)
    ) u_gate (
        .commit     (acc_ack),
        .addr       (acc_addr),
        .unlocked   (unlocked),
        .is_key     (is_key),
        .bank_we    (bank_we),
        .bank_wmask (bank_wmask)
    );
endmodule

// File: rtl/keylock_guard_chk.sv
module keylock_guard_chk #(
    parameter int            AW             = 8,
    parameter int            DW             = 32,
    parameter int            WAIT_STATES    = 2,
    parameter logic [AW-1:0] KEY_ADDR       = 8'h09,
    parameter logic [DW-1:0] STAT_FREE_MASK = 32'h0000_3F00
) (
    input logic          clk,
    input logic          por_n,
    input logic          sys_rst_n,
    input logic          acc_req,
    input logic [AW-1:0] acc_addr,
    input logic [DW-1:0] acc_wdata,
    input logic          acc_ack,
    input logic          bank_we,
    input logic [DW-1:0] bank_wmask,
    input logic          unlocked
);
    logic key_ack;
    assign key_ack = acc_ack && (acc_addr == KEY_ADDR);

    AST_ACK_GAP: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (acc_ack && WAIT_STATES > 0) |=> !acc_ack); // R2

    AST_WE_ON_ACK: assert property (@(posedge clk) disable iff (!por_n)
        bank_we |-> acc_ack); // R2

    AST_UNLOCK_BY_KEY2: assert property (@(posedge clk) disable iff (!por_n)
        $rose(unlocked) |-> $past(key_ack && acc_wdata[7:0] == 8'h53)); // R3

    AST_WRONG_KEY_LOCKS: assert property (@(posedge clk) disable iff (!por_n)
        (key_ack && acc_wdata[7:0] != 8'h53) |=> !unlocked); // R5

    AST_LOCKED_MASK: assert property (@(posedge clk) disable iff (!por_n)
        (!unlocked && bank_we) |-> (bank_wmask == '1 || bank_wmask == STAT_FREE_MASK)); // R4

    AST_KEY_NO_BANK: assert property (@(posedge clk) disable iff (!por_n)
        key_ack |-> !bank_we); // R9

    AST_SYSRST_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst_n |=> $stable(unlocked)); // R8
endmodule

bind keylock_guard keylock_guard_chk #(
    .AW(AW), .DW(DW), .WAIT_STATES(WAIT_STATES),
    .KEY_ADDR(KEY_ADDR), .STAT_FREE_MASK(STAT_FREE_MASK)
) u_chk (.*);

// File: tb/tb_keylock_guard.sv
module tb_keylock_guard;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int WS = 2;
    localparam logic [7:0] KEY  = 8'h09;
    localparam logic [7:0] STAT = 8'h03;
    localparam logic [31:0] FREE = 32'h0000_3F00;
    localparam logic [7:0] EX0 = 8'h0E;
    localparam logic [7:0] EX1 = 8'h0F;
    localparam int BKP_LO = 20;
    localparam int BKP_N  = 20;

    logic clk = 0;
    logic por_n = 0, sys_rst_n = 0;
    logic acc_req = 0;
    logic [AW-1:0] acc_addr = '0;
    logic [DW-1:0] acc_wdata = '0;
    logic acc_ack, bank_we, unlocked;
    logic [DW-1:0] bank_wmask;

    int total = 0, bad = 0;
    int mstate = 0; // 0 locked, 1 first key seen, 2 open

    always #5 clk = ~clk;

    keylock_guard dut (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .acc_req(acc_req),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_ack(acc_ack),
        .bank_we(bank_we), .bank_wmask(bank_wmask), .unlocked(unlocked)
    );

    function automatic logic [31:0] exp_mask(input logic [7:0] a, input int st);
        if (a == KEY) return '0;
        if (a == EX0 || a == EX1 || (int'(a) >= BKP_LO && int'(a) < BKP_LO + BKP_N)) return '1;
        if (st == 2) return '1;
        if (a == STAT) return FREE;
        return '0;
    endfunction

    function automatic int next_st(input int st, input logic [7:0] b);
        if (st == 1) return (b == 8'h53) ? 2 : 0;
        return (b == 8'hCA) ? 1 : 0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input string req);
        int waits = 0;
        logic [31:0] em;
        em = exp_mask(a, mstate);
        @(negedge clk);
        acc_req = 1; acc_addr = a; acc_wdata = d;
        #1;
        while (!acc_ack && waits < 20) begin
            waits++;
            @(negedge clk);
            #1;
        end
        check("R2 wait count", waits, WS);
        check({req, " bank_we"}, {31'd0, bank_we}, {31'd0, (em != 0)});
        check({req, " bank_wmask"}, bank_wmask, em);
        @(negedge clk);
        acc_req = 0;
        if (a == KEY) mstate = next_st(mstate, d[7:0]);
        #1;
        check({req, " unlocked"}, {31'd0, unlocked}, {31'd0, (mstate == 2)});
    endtask

    task automatic power_on;
        por_n = 0; sys_rst_n = 0;
        repeat (3) @(negedge clk);
        por_n = 1; sys_rst_n = 1;
        mstate = 0;
        #1;
        check("R1 reset unlocked", {31'd0, unlocked}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        power_on();
        do_write(8'h05, 32'hFFFF_FFFF, "R1 locked protected");
        do_write(STAT, 32'hFFFF_FFFF, "R4 locked status");
        do_write(8'h07, 32'h1, "R4 locked drop");
        do_write(EX0, 32'h1, "R7 exempt list");
        do_write(EX1, 32'h2, "R7 exempt list");
        do_write(8'(BKP_LO), 32'h3, "R7 backup low");
        do_write(8'(BKP_LO + BKP_N - 1), 32'h4, "R7 backup high");
        do_write(8'(BKP_LO + BKP_N), 32'h4, "R7 backup past end");
        do_write(KEY, 32'h53, "R5 key2 without key1");
        do_write(KEY, 32'hCA, "R3 key1");
        do_write(KEY, 32'hCA, "R5 repeated key1");
        do_write(KEY, 32'h53, "R5 key2 after repeat");
        do_write(KEY, 32'h1234_56CA, "R6 key1 upper bits");
        do_write(KEY, 32'hABCD_EF53, "R6 key2 upper bits");
        do_write(8'h05, 32'h9, "R9 unlocked protected");
        do_write(STAT, 32'h9, "R9 unlocked status");
        do_write(KEY + 8'd0, 32'hCA, "R5 key1 while open");
        do_write(KEY, 32'h53, "R3 reunlock");
        do_write(8'h06, 32'h0, "R10 stays open");
        do_write(EX0, 32'h0, "R10 stays open");
        // system reset leaves the lock state alone
        @(negedge clk);
        sys_rst_n = 0;
        repeat (3) @(negedge clk);
        #1;
        check("R8 held through sys reset", {31'd0, unlocked}, 32'd1);
        sys_rst_n = 1;
        // system reset in the middle of an access restarts the wait count
        @(negedge clk);
        acc_req = 1; acc_addr = 8'h05; acc_wdata = 0;
        @(negedge clk);
        sys_rst_n = 0;
        #1;
        check("R8 sys reset clears count", {31'd0, acc_ack}, 32'd0);
        @(negedge clk);
        sys_rst_n = 1;
        @(negedge clk);
        #1;
        check("R8 count restarted", {31'd0, acc_ack}, 32'd0);
        @(negedge clk);
        #1;
        check("R8 ack after full wait", {31'd0, acc_ack}, 32'd1);
        @(negedge clk);
        acc_req = 0;
        do_write(KEY, 32'h77, "R5 wrong key relocks");
        do_write(8'h05, 32'h0, "R4 dropped after relock");
        // power-on reset relocks
        do_write(KEY, 32'hCA, "R3 key1");
        do_write(KEY, 32'h53, "R3 key2");
        power_on();
        do_write(8'h05, 32'h0, "R1 locked after por");
        for (int i = 0; i < 400; i++) begin
            int r;
            logic [7:0] a;
            logic [31:0] d;
            r = int'($urandom % 8);
            d = $urandom;
            case (r)
                0, 1: begin
                    a = KEY;
                    case ($urandom % 4)
                        0: d[7:0] = 8'hCA;
                        1: d[7:0] = 8'h53;
                        2: d = {24'h0, 8'hCA};
                        default: ;
                    endcase
                end
                2: a = STAT;
                3: a = ($urandom % 2 == 0) ? EX0 : EX1;
                4: a = 8'(BKP_LO + int'($urandom % BKP_N));
                default: a = 8'($urandom % 64);
            endcase
            do_write(a, d, "R3 R5 R9 R10 random");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule